// File: doc/BRIEF.md
# Serial-Controlled Eight-Channel Low-Side Switch Controller

This block is the digital core of an eight-channel low-side power switch that a host drives over a four-wire serial link. A frame starts when chip select falls. At that moment each channel's "pin above threshold" comparator flag is captured into the shift register. Each SCLK rise then presents the next diagnostic bit on the serial output, and each SCLK fall takes in a new control bit from the serial input. When chip select returns high, the received byte is copied into the output latch, and the latch drives the active-low channel enables. A host finds open or shorted loads by comparing the byte it read back with the byte it wrote earlier.

Every frame write starts a blanking timer, sized in system-clock cycles from a clock-frequency parameter and a delay in microseconds. While the timer runs, inrush current cannot trip the protection. Once it has expired, any channel that is commanded on but whose pin still reads above threshold is switched off in the latch. Longer frames pass through the shift register unchanged, so several devices can share one chip select in a daisy chain. All serial inputs and the comparator flags are brought into the system clock domain through two-flop synchronizers.

Top module: `octal_lsd_ctrl`

## Requirements
- R1: `sdo_oe` is 1 exactly while `cs_n` is 0, and 0 while `cs_n` is 1, so that the pad drives serial output only during a frame.
- R2: On each falling edge of `cs_n`, the eight `diag_hi` flags (1 = pin above the 1.8 V threshold) are loaded into the shift register, and they are the first eight bits read back on `sdo` in that frame.
- R3: Bit 7 travels first and bit 0 last, both on `sdi` and on `sdo`.
- R4: `sdo` changes only after an SCLK rise and holds through the following SCLK fall. `sdi` is taken at the SCLK fall, so its value during the high phase before the fall is irrelevant.
- R5: On each rising edge of `cs_n`, the shift register is copied into the output latch and `drv_n[i]` equals latch bit i. A 0 in the byte turns the channel on (`drv_n[i]` = 0) and a 1 turns it off.
- R6: For BLANK system-clock cycles after each latch update, no comparator flag changes the latch. BLANK is (CLK_HZ/1000)*BLANK_US/1000, with a minimum of 1.
- R7: After the blanking window, and for as long as no new frame arrives, a channel that is on and whose flag is 1 is turned off (`drv_n[i]` goes to 1). Channels that are on with flag 0, and channels that are off, keep their values.
- R8: In a frame longer than 8 bits, `sdo` presents each `sdi` bit again 8 SCLK cycles after it was received, and only the last 8 bits received are latched.
- R9: A low level on `rst_n` forces every `drv_n` bit to 1 at once, without waiting for a clock edge, and clears the shift register and the blanking timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial control data in, bit 7 first |
| diag_hi | input | 8 | Per-channel comparator flags, 1 = pin above threshold |
| sdo | output | 1 | Serial diagnostic data out |
| sdo_oe | output | 1 | Output enable for the serial-out pad driver |
| drv_n | output | 8 | Channel drive enables, 0 = channel switched on |

## Verification
A wrong shift-register state shows on `sdo` within the same frame, one bit per SCLK rise, and in the byte latched onto `drv_n` a few system clocks after chip select rises. Every one of the 256 control bytes is written and read back, and each read returns the previous byte, so a bit-order error or a stuck bit is caught within two frames. A wrong blanking counter moves the moment at which a shorted channel drops out. The bench therefore samples `drv_n` shortly before and shortly after the expected expiry, which catches an off-by-a-window counter within one timeout. Latch corruption from a wrong protection mask is visible at `drv_n` on the cycle after the timer expires.

// File: rtl/olsd_pkg.sv
package olsd_pkg;

    // Two-flop synchronizer plus edge-detect history for one serial line.
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } edge_st_t;

    // Blanking window length in system-clock cycles, never below one.
    function automatic int blank_cycles(input int clk_hz, input int delay_us);
        int c;
        c = (clk_hz / 1000) * delay_us / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/olsd_sync.sv
module olsd_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/olsd_edge_sync.sv
module olsd_edge_sync #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    import olsd_pkg::*;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = d;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: IDLE, s2: IDLE, prev: IDLE};
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.prev;
    assign fall = ~st_q.s2 & st_q.prev;

endmodule

// File: rtl/olsd_shift.sv
module olsd_shift #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         si,
    input  logic [N-1:0] flags,
    output logic [N-1:0] sr,
    output logic         so
);
    typedef struct packed {
        logic [N-1:0] sr;
        logic         so;
        logic         active;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.sr     = flags;
            st_d.so     = flags[N-1];
        end else if (cs_rise) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (sck_rise) st_d.so = st_q.sr[N-1];
            if (sck_fall) st_d.sr = {st_q.sr[N-2:0], si};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr = st_q.sr;
    assign so = st_q.so;

    // R2: the frame opens with the synchronized flags in the register
    a_r2_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (sr == $past(flags)));

    // R4: serial output moves only on an SCLK rise or a new frame
    a_r4_so_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !cs_fall) |=> $stable(so));

endmodule

// File: rtl/olsd_protect.sv
module olsd_protect #(
    parameter int N     = 8,
    parameter int BLANK = 16000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] sr,
    input  logic [N-1:0] flags,
    output logic [N-1:0] latch
);
    localparam int CW = $clog2(BLANK + 1);

    typedef struct packed {
        logic [N-1:0]  latch;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.latch = sr;
            st_d.cnt   = CW'(BLANK);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end else begin
            // on-channel (0) whose pin stays high is forced off (1)
            st_d.latch = st_q.latch | flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{latch: '1, cnt: '0};
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;

    // R5: a frame end copies the shift register into the latch
    a_r5_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (latch == $past(sr)));

    // R6: flags cannot touch the latch inside the blanking window
    a_r6_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && !load) |=> $stable(latch));

    // R7: outside the window no channel is switched on, and only flagged ones go off
    a_r7_only_faulty_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !load) |=>
            (((latch & ~$past(latch) & ~$past(flags)) == '0) &&
             (($past(latch) & ~latch) == '0)));

    // R7: every flagged channel ends up off once the window is over
    a_r7_faulty_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !load) |=> ((~latch & $past(flags)) == '0));

endmodule

// File: rtl/octal_lsd_ctrl.sv
module octal_lsd_ctrl #(
    parameter int N_CH     = 8,
    parameter int CLK_HZ   = 100_000_000,
    parameter int BLANK_US = 160
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            sdi,
    input  logic [N_CH-1:0] diag_hi,
    output logic            sdo,
    output logic            sdo_oe,
    output logic [N_CH-1:0] drv_n
);
    localparam int BLANK = olsd_pkg::blank_cycles(CLK_HZ, BLANK_US);

    logic            cs_rise, cs_fall;
    logic            sck_rise, sck_fall;
    logic            si_s;
    logic [N_CH-1:0] flags_s;
    logic [N_CH-1:0] sr;
    logic            so;

    olsd_edge_sync #(.IDLE(1'b1)) u_cs (
        .clk (clk), .rst_n (rst_n), .d (cs_n),
        .rise(cs_rise), .fall(cs_fall)
    );

    olsd_edge_sync #(.IDLE(1'b0)) u_sck (
        .clk (clk), .rst_n (rst_n), .d (sclk),
        .rise(sck_rise), .fall(sck_fall)
    );

    olsd_sync #(.W(1)) u_si_sync (
        .clk(clk), .rst_n(rst_n), .d(sdi), .q(si_s)
    );

    olsd_sync #(.W(N_CH)) u_flag_sync (
        .clk(clk), .rst_n(rst_n), .d(diag_hi), .q(flags_s)
    );

    olsd_shift #(.N(N_CH)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .si      (si_s),
        .flags   (flags_s),
        .sr      (sr),
        .so      (so)
    );

    olsd_protect #(.N(N_CH), .BLANK(BLANK)) u_protect (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cs_rise),
        .sr   (sr),
        .flags(flags_s),
        .latch(drv_n)
    );

    assign sdo    = so;
    assign sdo_oe = ~cs_n;

endmodule

// File: tb/octal_lsd_ctrl_bench.sv
module octal_lsd_ctrl_bench;
    localparam int CLK_HZ   = 1_000_000;
    localparam int BLANK_US = 160;
    localparam int BLANK    = (CLK_HZ / 1000) * BLANK_US / 1000;
    localparam int H        = 5;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, sclk, sdi;
    logic [7:0] diag_hi;
    logic       sdo, sdo_oe;
    logic [7:0] drv_n;

    int checks = 0;
    int errors = 0;
    int r4_bad = 0;

    always #2 clk = ~clk;

    octal_lsd_ctrl #(.N_CH(8), .CLK_HZ(CLK_HZ), .BLANK_US(BLANK_US)) u_octal_lsd_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .diag_hi(diag_hi), .sdo(sdo), .sdo_oe(sdo_oe), .drv_n(drv_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame, bit nbits-1 first; sdi is wrong during the high phase and
    // only settles shortly before the fall (R4).
    task automatic xfer(input int nbits, input logic [31:0] tx, output logic [31:0] rx);
        rx   = '0;
        cs_n = 1'b0;
        tick(H);
        for (int i = nbits - 1; i >= 0; i--) begin
            sclk = 1'b1;
            sdi  = ~tx[i];
            tick(2);
            sdi  = tx[i];
            tick(H - 2);
            rx[i] = sdo;
            sclk = 1'b0;
            tick(H);
            if (sdo !== rx[i]) r4_bad++;
        end
        cs_n = 1'b1;
        tick(H);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rx;
        logic [7:0]  exp_diag;

        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; diag_hi = 8'h00;
        tick(3);
        chk(drv_n == 8'hFF, "R9 reset drives off", drv_n, 8'hFF);
        chk(sdo_oe == 1'b0, "R1 oe low while deselected", sdo_oe, 0);
        rst_n = 1'b1;
        tick(3);

        // R1: the output enable follows chip select directly
        cs_n = 1'b0; #1;
        chk(sdo_oe == 1'b1, "R1 oe high while selected", sdo_oe, 1);
        cs_n = 1'b1; #1;
        chk(sdo_oe == 1'b0, "R1 oe low after deselect", sdo_oe, 0);
        tick(H);

        // R2 R3 R5: all 256 control bytes; each read returns the previous byte as flags
        for (int b = 0; b < 256; b++) begin
            exp_diag = diag_hi;
            xfer(8, 32'(b), rx);
            chk(rx[7:0] == exp_diag, "R2 R3 readback of flags", rx[7:0], exp_diag);
            chk(drv_n == 8'(b), "R5 latched byte on drv_n", drv_n, 8'(b));
            chk(sdo_oe == 1'b0, "R1 oe low between frames", sdo_oe, 0);
            diag_hi = 8'(b);
        end
        chk(r4_bad == 0, "R4 sdo stable across SCLK fall", r4_bad, 0);

        // R8: daisy chain, 16 and 24 bit frames
        tick(BLANK + 20);
        diag_hi = 8'h3C;
        tick(H);
        xfer(16, 32'h96E1, rx);
        chk(rx[15:0] == 16'h3C96, "R8 16-bit pass-through", rx[15:0], 16'h3C96);
        chk(drv_n == 8'hE1, "R8 last byte latched", drv_n, 8'hE1);
        diag_hi = 8'hE1;
        tick(H);
        xfer(24, 32'h1234F0, rx);
        chk(rx[23:0] == 24'hE11234, "R8 24-bit pass-through", rx[23:0], 24'hE11234);
        chk(drv_n == 8'hF0, "R8 last byte latched 24", drv_n, 8'hF0);
        diag_hi = 8'hF0;
        tick(BLANK + 20);

        // R6 R7: each channel alone, shorted (pin stays high while on)
        for (int ch = 0; ch < 8; ch++) begin
            logic [7:0] cmd;
            cmd = ~(8'h01 << ch);
            diag_hi = 8'hFF;
            tick(H);
            xfer(8, 32'(cmd), rx);
            chk(drv_n == cmd, "R6 on during blanking start", drv_n, cmd);
            tick(BLANK - 20);
            chk(drv_n == cmd, "R6 on near blanking end", drv_n, cmd);
            tick(40);
            chk(drv_n == 8'hFF, "R7 shorted channel off", drv_n, 8'hFF);
        end

        // R7: one faulty channel among several on ones; off channels untouched
        diag_hi = 8'h5E;
        tick(H);
        xfer(8, 32'h5A, rx);
        tick(BLANK + 40);
        chk(drv_n == 8'h5E, "R7 only faulty channel cleared", drv_n, 8'h5E);

        // R7: a fault that appears after the window is still acted on
        diag_hi = 8'hF0;
        tick(H);
        xfer(8, 32'hF0, rx);
        tick(BLANK + 40);
        chk(drv_n == 8'hF0, "R7 healthy channels stay on", drv_n, 8'hF0);
        diag_hi = 8'hF1;
        tick(10);
        chk(drv_n == 8'hF1, "R7 late fault cleared", drv_n, 8'hF1);

        // R9: asynchronous reset during blanking
        diag_hi = 8'h00;
        tick(H);
        xfer(8, 32'h00, rx);
        chk(drv_n == 8'h00, "R5 all on before reset", drv_n, 8'h00);
        rst_n = 1'b0; #1;
        chk(drv_n == 8'hFF, "R9 async reset forces off", drv_n, 8'hFF);
        tick(2);
        rst_n = 1'b1;
        tick(3);
        chk(drv_n == 8'hFF, "R9 off after reset release", drv_n, 8'hFF);
        diag_hi = 8'h81;
        tick(H);
        xfer(8, 32'h7E, rx);
        chk(rx[7:0] == 8'h81, "R2 readback after reset", rx[7:0], 8'h81);
        chk(drv_n == 8'h7E, "R5 latch after reset", drv_n, 8'h7E);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule